// File: doc/BRIEF.md
# Serial ADC Conversion Reader

This block is the host side of a link to a 12-bit successive-approximation converter with a three-wire serial port: a chip select, a serial clock and a data line from the converter. When it gets a start strobe, it pulls chip select low. It then runs sixteen serial clock periods, split into two 8-bit groups, and samples the data line on every rising clock edge. From that capture it rebuilds the 12-bit conversion code. The converter moves its data line on falling edges. The serial clock idles at the level given by the `clk_idle_hi` input: low for mode 0,0 and high for mode 1,1. In both modes each bit period starts with a low half and ends with a high half, so the sampling edge falls in the middle of the period.

The sixteen captured bits arrive in this order:
- two bits with no defined value;
- the converter's null bit;
- the code from bit 11 down to bit 0;
- one repeated copy of bit 1.

The reader drops the two undefined bits and the trailing repeat. It reports the null bit as a framing error. The serial clock comes from the system clock through a parameter `HALF_DIV`, which sets the number of system cycles in each clock half. An elaboration-time check stops the build when, for the given system clock period, the divider would break any of these limits:
- a minimum high or low time;
- a maximum serial clock rate;
- a 1.2 ms limit from the end of sampling to the last data bit.

The result leaves on a valid/ready stream. The code and the error flag stay fixed while `res_valid` is high and `res_ready` is low. A start strobe is accepted only when the reader is idle and no result is waiting, so back-pressure stops new conversions rather than dropping results. After each frame, chip select stays high for a minimum time. Start strobes that arrive during that guard time are ignored.

Top module: `adc_spi_reader`

## Requirements
- R1: While reset is held and right after it, `adc_cs_n` is 1, `adc_sclk` equals `clk_idle_hi`, and `res_valid` is 0.
- R2: Each accepted start produces one chip-select-low frame that contains exactly 16 rising edges of `adc_sclk`.
- R3: While `adc_cs_n` is 0, every high or low phase of `adc_sclk` between two toggles lasts at least `HALF_DIV` system clock cycles.
- R4: `adc_cs_n` falls at least `ceil(T_SETUP_PS/SYS_PERIOD_PS)` system cycles before the first rising edge of `adc_sclk`.
- R5: The captured bits are c15 (first) down to c0 (last). `res_data[11:0]` equals c12..c1: bits 11 to 7 come from the first byte, and the repeated bit in c0 is discarded.
- R6: `res_frame_err` equals the captured null bit c13, so it is 1 exactly when the converter's null bit reads 1.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_data` and `res_frame_err` hold their values, and a start strobe starts no frame.
- R8: A start strobe that arrives while a frame is running is ignored and causes no second frame.
- R9: Between frames `adc_cs_n` stays high for at least `ceil(T_CSH_PS/SYS_PERIOD_PS)` system cycles, and a start strobe that arrives in that window is ignored.
- R10: Whenever `adc_cs_n` is 1, `adc_sclk` sits at its idle level `clk_idle_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_idle_hi | input | 1 | Serial clock idle level: 0 for mode 0,0, 1 for mode 1,1 |
| start | input | 1 | One-cycle request to fetch one conversion |
| adc_dout | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Chip select to the converter, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 12 | Rebuilt conversion code |
| res_frame_err | output | 1 | Null bit read as 1 in this frame |

## Verification
The assertions watch, on every cycle, the timing rules that can be seen on the pins:
- the idle level of the serial clock while chip select is high;
- the minimum width of each clock phase;
- the chip-select setup time before the first rising edge;
- the chip-select high time between frames;
- the stream holding its values under back-pressure.

Only the bench's scenarios, which run against a behavioural converter model, can show the rest. That includes the bit reassembly for several codes in both clock modes, the null-bit error flag, the exact count of 16 rising edges, and the fact that start strobes during a frame, during the guard time or while a result is waiting never start a frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_SETUP = 2'd1,
    RD_SHIFT = 2'd2,
    RD_GUARD = 2'd3
  } rd_state_t;

  // two unknown bits + null bit + 12 code bits + one repeated bit
  localparam int unsigned RES_BITS   = 12;
  localparam int unsigned FRAME_BITS = RES_BITS + 4;

  function automatic longint unsigned ceil_div(longint unsigned num, longint unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int unsigned HALF_DIV   = 32,
  parameter int unsigned FRAME_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_hi,
  output logic rise_stb,
  output logic frame_done
);
  localparam int unsigned DIV_W = $clog2(HALF_DIV + 1);
  localparam int unsigned BIT_W = $clog2(FRAME_BITS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic             half_q;
  logic             div_end;

  assign div_end    = run && (div_q == DIV_LAST);
  assign rise_stb   = div_end && !half_q;
  assign frame_done = div_end && half_q && (bit_q == BIT_LAST);
  assign phase_hi   = half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bit_q  <= '0;
      half_q <= 1'b0;
    end else if (!run) begin
      div_q  <= '0;
      bit_q  <= '0;
      half_q <= 1'b0;
    end else if (div_end) begin
      div_q  <= '0;
      half_q <= !half_q;
      if (half_q) bit_q <= bit_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int unsigned RES_BITS   = 12,
  parameter int unsigned FRAME_BITS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                din,
  output logic [RES_BITS-1:0] code,
  output logic                null_bit
);
  logic [FRAME_BITS-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_q <= '0;
    else if (shift_en) cap_q <= {cap_q[FRAME_BITS-2:0], din};
  end

  // cap_q[0] is the replayed bit 1; the code sits just above it
  assign code     = cap_q[RES_BITS:1];
  assign null_bit = cap_q[RES_BITS+1];
endmodule

// File: rtl/adc_spi_reader.sv
module adc_spi_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned SYS_PERIOD_PS = 10000,
  parameter int unsigned HALF_DIV      = 32,
  parameter int unsigned T_SETUP_PS    = 100000,
  parameter int unsigned T_CSH_PS      = 625000,
  parameter int unsigned T_HALF_MIN_PS = 312000,
  parameter int unsigned T_SCLK_MIN_PS = 625000,
  parameter int unsigned T_WINDOW_PS   = 1200000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_idle_hi,
  input  logic                start,
  input  logic                adc_dout,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [RES_BITS-1:0] res_data,
  output logic                res_frame_err
);
  localparam int unsigned SETUP_CYC = int'(ceil_div(T_SETUP_PS, SYS_PERIOD_PS)) < 1 ? 1
                                    : int'(ceil_div(T_SETUP_PS, SYS_PERIOD_PS));
  localparam int unsigned CSH_CYC   = int'(ceil_div(T_CSH_PS, SYS_PERIOD_PS)) < 1 ? 1
                                    : int'(ceil_div(T_CSH_PS, SYS_PERIOD_PS));
  localparam int unsigned WAIT_MAX  = SETUP_CYC > CSH_CYC ? SETUP_CYC : CSH_CYC;
  localparam int unsigned WAIT_W    = $clog2(WAIT_MAX + 1);

  localparam longint unsigned HALF_PS   = longint'(HALF_DIV) * longint'(SYS_PERIOD_PS);
  // sampling ends after 2 clocks; 14 more carry the 12 code bits out
  localparam longint unsigned WINDOW_PS = 28 * HALF_PS;
  localparam bit TIMING_OK = (HALF_DIV >= 1)
                          && (HALF_PS >= longint'(T_HALF_MIN_PS))
                          && (2 * HALF_PS >= longint'(T_SCLK_MIN_PS))
                          && (WINDOW_PS <= longint'(T_WINDOW_PS));

  if (!TIMING_OK) begin : g_bad_timing
    $error("adc_spi_reader: HALF_DIV breaks serial clock timing limits");
  end

  rd_state_t            st_q;
  logic [WAIT_W-1:0]    wait_q;
  logic                 phase_hi, rise_stb, frame_done;
  logic [RES_BITS-1:0]  cap_code;
  logic                 cap_null;
  logic                 vld_q, err_q;
  logic [RES_BITS-1:0]  data_q;
  logic                 accept;

  assign accept = (st_q == RD_IDLE) && start && !vld_q;

  adc_rd_sclk_gen #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_sclk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (st_q == RD_SHIFT),
    .phase_hi   (phase_hi),
    .rise_stb   (rise_stb),
    .frame_done (frame_done)
  );

  adc_rd_capture #(.RES_BITS(RES_BITS), .FRAME_BITS(FRAME_BITS)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (rise_stb),
    .din      (adc_dout),
    .code     (cap_code),
    .null_bit (cap_null)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_GUARD;
      wait_q <= '0;
    end else begin
      unique case (st_q)
        RD_IDLE: if (accept) begin
          st_q   <= RD_SETUP;
          wait_q <= '0;
        end
        RD_SETUP: begin
          if (wait_q == WAIT_W'(SETUP_CYC - 1)) st_q <= RD_SHIFT;
          wait_q <= wait_q + 1'b1;
        end
        RD_SHIFT: if (frame_done) begin
          st_q   <= RD_GUARD;
          wait_q <= '0;
        end
        RD_GUARD: begin
          if (wait_q == WAIT_W'(CSH_CYC - 1)) st_q <= RD_IDLE;
          else                               wait_q <= wait_q + 1'b1;
        end
        default: st_q <= RD_GUARD;
      endcase
    end
  end

  // the last capture lands on the rise before frame_done, so cap_code is complete
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else if (frame_done) begin
      vld_q  <= 1'b1;
      err_q  <= cap_null;
      data_q <= cap_code;
    end else if (vld_q && res_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign adc_cs_n      = !((st_q == RD_SETUP) || (st_q == RD_SHIFT));
  assign adc_sclk      = (st_q == RD_SHIFT) ? phase_hi : clk_idle_hi;
  assign res_valid     = vld_q;
  assign res_data      = data_q;
  assign res_frame_err = err_q;
endmodule

// File: rtl/adc_spi_reader_chk.sv
module adc_spi_reader_chk #(
  parameter int unsigned HALF_DIV  = 32,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned CSH_CYC   = 7,
  parameter int unsigned RES_BITS  = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clk_idle_hi,
  input logic                adc_cs_n,
  input logic                adc_sclk,
  input logic                res_valid,
  input logic                res_ready,
  input logic [RES_BITS-1:0] res_data,
  input logic                res_frame_err
);
  logic [15:0] hi_cnt, lo_cnt, run_cnt;
  logic        sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      lo_cnt  <= '0;
      run_cnt <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_d  <= adc_sclk;
      hi_cnt  <= adc_cs_n  ? ((&hi_cnt) ? hi_cnt : hi_cnt + 1'b1) : '0;
      lo_cnt  <= !adc_cs_n ? ((&lo_cnt) ? lo_cnt : lo_cnt + 1'b1) : '0;
      run_cnt <= (adc_sclk != sclk_d) ? 16'd1 : ((&run_cnt) ? run_cnt : run_cnt + 1'b1);
    end
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> (adc_sclk == clk_idle_hi)); // R10

  AST_PHASE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && $past(!adc_cs_n) && (adc_sclk != sclk_d) && (lo_cnt > 16'(HALF_DIV)))
      |-> (run_cnt >= 16'(HALF_DIV))); // R3

  AST_CS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && $rose(adc_sclk)) |-> (lo_cnt >= 16'(SETUP_CYC))); // R4

  AST_CS_HIGH_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> (hi_cnt >= 16'(CSH_CYC))); // R9

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_frame_err))); // R7
endmodule

bind adc_spi_reader adc_spi_reader_chk #(
  .HALF_DIV  (HALF_DIV),
  .SETUP_CYC (SETUP_CYC),
  .CSH_CYC   (CSH_CYC),
  .RES_BITS  (adc_rd_pkg::RES_BITS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clk_idle_hi   (clk_idle_hi),
  .adc_cs_n      (adc_cs_n),
  .adc_sclk      (adc_sclk),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_data      (res_data),
  .res_frame_err (res_frame_err)
);

// File: tb/test_adc_spi_reader.sv
`timescale 1ns/1ps
module test_adc_spi_reader;
  localparam int CLK_PERIOD = 100;
  localparam int TB_SYS_PS  = 100000;
  localparam int TB_HALF    = 4;
  localparam int EXP_SETUP  = (100000 + TB_SYS_PS - 1) / TB_SYS_PS;
  localparam int EXP_CSH    = (625000 + TB_SYS_PS - 1) / TB_SYS_PS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_idle_hi = 1'b0;
  logic        start = 1'b0;
  logic        adc_dout = 1'b1;
  logic        res_ready = 1'b1;
  logic        adc_cs_n, adc_sclk, res_valid, res_frame_err;
  logic [11:0] res_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  adc_spi_reader #(.SYS_PERIOD_PS(TB_SYS_PS), .HALF_DIV(TB_HALF)) i_adc_spi_reader (
    .clk(clk), .rst_n(rst_n), .clk_idle_hi(clk_idle_hi), .start(start),
    .adc_dout(adc_dout), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_frame_err(res_frame_err)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  // behavioural converter: undefined bits read 1, then null, MSB-first, LSB-first, zeros
  logic [11:0] m_code = '0;
  logic        m_null = 1'b0;
  int          m_rise = 0;

  function automatic logic adc_bit(int r);
    if (r <= 1)  return 1'b1;
    if (r == 2)  return m_null;
    if (r <= 14) return m_code[14-r];
    if (r <= 25) return m_code[r-14];
    return 1'b0;
  endfunction

  always @(negedge adc_cs_n) begin m_rise = 0; adc_dout = 1'b1; end
  always @(posedge adc_sclk) if (!adc_cs_n) m_rise = m_rise + 1;
  always @(negedge adc_sclk) if (!adc_cs_n) adc_dout = adc_bit(m_rise);

  // pin-level timing monitor, sampled away from the active edge
  int p_cs = 1, p_sclk = 0;
  int hi_run = 0, cs_age = 0, lvl_run = 0, togs = 0;
  int mon_rises = 0, mon_setup = -1, mon_minhalf = 1000000, mon_guard = 1000000;

  always @(negedge clk) begin
    cycles = cycles + 1;
    if (!rst_n) begin
      hi_run = 0;
    end else begin
      if (p_cs == 1 && !adc_cs_n) begin
        mon_guard = hi_run; hi_run = 0; cs_age = 0; lvl_run = 0; togs = 0;
        mon_rises = 0; mon_setup = -1; mon_minhalf = 1000000;
      end else if (!adc_cs_n) begin
        cs_age = cs_age + 1;
      end
      if (adc_cs_n) hi_run = hi_run + 1;
      if (!adc_cs_n && int'(adc_sclk) != p_sclk) begin
        if (togs > 0 && lvl_run < mon_minhalf) mon_minhalf = lvl_run;
        togs = togs + 1; lvl_run = 0;
        if (adc_sclk) begin
          mon_rises = mon_rises + 1;
          if (mon_setup < 0) mon_setup = cs_age;
        end
      end
      lvl_run = lvl_run + 1;
    end
    p_cs = int'(adc_cs_n);
    p_sclk = int'(adc_sclk);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_valid(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (res_valid) begin seen = 1'b1; break; end
    end
  endtask

  task automatic cs_stays_high(input int n, input string tag);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!adc_cs_n) ok = 1'b0;
    end
    chk(ok, tag, int'(ok), 1);
  endtask

  task automatic run_frame(input logic [11:0] code, input logic nullv, input logic mode);
    bit seen;
    @(negedge clk);
    clk_idle_hi = mode; m_code = code; m_null = nullv;
    pulse_start();
    wait_valid(seen);
    chk(seen, "R2 frame completes", int'(seen), 1);
    chk(res_data == code, "R5 code rebuilt", int'(res_data), int'(code));
    chk(res_frame_err == nullv, "R6 null bit flag", int'(res_frame_err), int'(nullv));
    chk(mon_rises == 16, "R2 rising edges", mon_rises, 16);
    chk(mon_minhalf >= TB_HALF, "R3 phase width", mon_minhalf, TB_HALF);
    chk(mon_setup >= EXP_SETUP, "R4 cs setup", mon_setup, EXP_SETUP);
    chk(adc_sclk == mode, "R10 idle level", int'(adc_sclk), int'(mode));
  endtask

  task automatic t_reset();
    chk(adc_cs_n == 1'b1, "R1 cs_n in reset", int'(adc_cs_n), 1);
    chk(res_valid == 1'b0, "R1 valid in reset", int'(res_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(adc_cs_n == 1'b1 && adc_sclk == clk_idle_hi, "R1 idle after reset",
        int'({adc_cs_n, adc_sclk}), int'({1'b1, clk_idle_hi}));
    chk(res_valid == 1'b0, "R1 valid after reset", int'(res_valid), 0);
    repeat (EXP_CSH + 2) @(negedge clk);
  endtask

  task automatic t_modes();
    run_frame(12'hABC, 1'b0, 1'b0);
    repeat (EXP_CSH + 2) @(negedge clk);
    run_frame(12'h000, 1'b0, 1'b1);
    repeat (EXP_CSH + 2) @(negedge clk);
    run_frame(12'hFFF, 1'b0, 1'b0);
    repeat (EXP_CSH + 2) @(negedge clk);
    run_frame(12'h5A5, 1'b1, 1'b1);   // R6 null bit forced to 1
    repeat (EXP_CSH + 2) @(negedge clk);
    run_frame(12'h081, 1'b0, 1'b1);   // bit 7 and bit 0 isolated, R5
    repeat (EXP_CSH + 2) @(negedge clk);
  endtask

  task automatic t_backpressure();
    bit stable = 1'b1;
    @(negedge clk); res_ready = 1'b0;
    run_frame(12'h3C6, 1'b0, 1'b0);
    pulse_start();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!res_valid || res_data != 12'h3C6 || adc_cs_n != 1'b1) stable = 1'b0;
    end
    chk(stable, "R7 hold and no frame while pending", int'(stable), 1);
    res_ready = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 valid drops on ready", int'(res_valid), 0);
    cs_stays_high(30, "R7 start while pending ignored");
  endtask

  task automatic t_busy_start();
    bit seen;
    @(negedge clk); clk_idle_hi = 1'b1; m_code = 12'h9E1; m_null = 1'b0;
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    wait_valid(seen);
    chk(seen && res_data == 12'h9E1, "R8 frame unaffected", int'(res_data), 'h9E1);
    cs_stays_high(60, "R8 start during frame ignored");
  endtask

  task automatic t_guard();
    bit seen, fell;
    @(negedge clk); clk_idle_hi = 1'b0; m_code = 12'h2D4; m_null = 1'b0;
    pulse_start();
    wait_valid(seen);
    pulse_start();
    cs_stays_high(40, "R9 start during guard ignored");
    run_frame(12'h7E3, 1'b0, 1'b0);
    @(negedge clk); start = 1'b1;     // held from the first guard cycle
    fell = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!adc_cs_n) begin fell = 1'b1; break; end
    end
    start = 1'b0;
    chk(fell && mon_guard >= EXP_CSH, "R9 cs high time", mon_guard, EXP_CSH);
    wait_valid(seen);
    chk(seen && res_data == 12'h7E3, "R5 back-to-back code", int'(res_data), 'h7E3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_modes();
    t_backpressure();
    t_busy_start();
    t_guard();
    repeat (20) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    failures = failures + 1;
    checks = checks + 1;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule